// File: doc/BRIEF.md
# Secure access remap unit

This block lets a bus master that has been barred from certain peripheral registers still reach a chosen few of them. It does this through a small window of channels. Software fills a remap table with one target address per channel. Each target must lie in the peripheral region, so an entry outside that region is refused. A read or write to channel word n of the channel window is then sent out on a single-beat master port, to the address held in table entry n. The channel's own address is not used.

Use of a channel is gated. Writing a channel number to the unlock register arms that channel for exactly one access. Any other access is blocked and answered with an error. Three sticky status bits record problems: a refused table write, a master-side bus error and a blocked access. An enable/disable/clear register set turns these bits into one maskable interrupt.

Top module: `sec_remap`

## Requirements
- R1: An armed access to channel n drives a master transfer at the address in table entry n, with the same write flag and write data. For a read, the master read data is returned on `chn_rdata_o`.
- R2: There are `NUM_CH` (default 63) table entries at config word addresses 0..NUM_CH-1. An accepted write to an entry reads back unchanged, including the last entry, 62.
- R3: A table write whose data is below 0xFFFC0000 sets status bit 0 (address error). Data from 0xFFFC0000 through 0xFFFFFFFF is accepted without setting it.
- R4: A refused table write leaves the entry holding its previous value.
- R5: When the master side answers with `mst_err_i`, the channel access completes with `chn_err_o`=1 and status bit 1 (bus error) is set.
- R6: A 1 written to a bit of the enable register (config word 67) sets that mask bit. A 1 written to the disable register (word 68) clears it. The mask reads back at word 66.
- R7: `irq_o` is high exactly while some status bit (read at word 65) and its mask bit are both 1. A status bit clears only when a 1 is written to the clear register (word 69).
- R8: Writing channel number c to the unlock register (word 64) arms c for one access. An access to any channel that is not armed produces no master transfer, completes with `chn_err_o`=1, and sets status bit 2 (unlock error). Every access consumes the arming.
- R9: The channel access is stalled until the master side returns ready or error. `chn_ack_o` follows one cycle after that answer. `mst_addr_o` stays stable while `mst_valid_o` waits.
- R10: After reset the status and mask registers are 0, `irq_o` is 0, and no master or channel transfer is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_req_i | input | 1 | Config port access strobe |
| cfg_we_i | input | 1 | Config write when 1 |
| cfg_addr_i | input | CW+1 | Config word address |
| cfg_wdata_i | input | DW | Config write data |
| cfg_rdata_o | output | DW | Config read data, combinational |
| chn_req_i | input | 1 | Channel access request, held until ack |
| chn_we_i | input | 1 | Channel write when 1 |
| chn_idx_i | input | CW | Channel word index |
| chn_wdata_i | input | DW | Channel write data |
| chn_rdata_o | output | DW | Channel read data, valid with ack |
| chn_ack_o | output | 1 | Channel access complete (one cycle) |
| chn_err_o | output | 1 | Channel access failed, valid with ack |
| mst_valid_o | output | 1 | Master transfer request |
| mst_we_o | output | 1 | Master write flag |
| mst_addr_o | output | DW | Master target address |
| mst_wdata_o | output | DW | Master write data |
| mst_ready_i | input | 1 | Master transfer done |
| mst_err_i | input | 1 | Master transfer error |
| mst_rdata_i | input | DW | Master read data |
| irq_o | output | 1 | Interrupt request |

## Verification
Forwarding is driven by a mix of directed and seeded random channel accesses. The random accesses vary the channel, the direction, the data and the master latency from zero to three wait cycles. This separates a correct table lookup from one that uses the channel index, and a correct stall from a fixed-latency response. The gating checks form a set of accesses: never unlocked, unlocked twice in a row, and unlocked for another channel. Together they tell true one-shot arming apart from a sticky arm or an ignored channel number. Table writes sit exactly on the range boundary and just below it, which exposes an off-by-one compare. The interrupt is stepped through enable, disable and clear while a status bit is held. This shows that mask and status act independently.

// File: rtl/sru_pkg.sv
package sru_pkg;
  localparam int ST_W   = 3;
  localparam int ST_ADR = 0;
  localparam int ST_BUS = 1;
  localparam int ST_LCK = 2;

  // control register offsets above the table region
  localparam int OFS_UNLOCK = 0;
  localparam int OFS_STATUS = 1;
  localparam int OFS_MASK   = 2;
  localparam int OFS_IEN    = 3;
  localparam int OFS_IDIS   = 4;
  localparam int OFS_ICLR   = 5;

  typedef enum logic [1:0] {FS_IDLE, FS_FWD, FS_RESP} fwd_st_e;
endpackage

// File: rtl/sru_table.sv
module sru_table #(
  parameter int          NUM_CH   = 63,
  parameter int          CW       = 6,
  parameter int          DW       = 32,
  parameter logic [31:0] RANGE_LO = 32'hFFFC_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [CW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [CW-1:0] cfg_idx_i,
  output logic [DW-1:0] cfg_data_o,
  input  logic [CW-1:0] fwd_idx_i,
  output logic [DW-1:0] fwd_addr_o,
  output logic          range_err_o
);
  localparam logic [CW:0] NUM_V = NUM_CH[CW:0];

  logic [DW-1:0] ent_q [NUM_CH];
  logic          in_rng;

  assign in_rng      = wr_data_i >= RANGE_LO[DW-1:0];
  assign range_err_o = wr_en_i && !in_rng;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      ent_q[g] <= '0;
      else if (wr_en_i && in_rng && wr_idx_i == CW'(g)) ent_q[g] <= wr_data_i;
    end
  end

  assign cfg_data_o = ({1'b0, cfg_idx_i} < NUM_V) ? ent_q[cfg_idx_i] : '0;
  assign fwd_addr_o = ({1'b0, fwd_idx_i} < NUM_V) ? ent_q[fwd_idx_i] : '0;
endmodule

// File: rtl/sru_irq.sv
module sru_irq #(
  parameter int NS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] set_i,
  input  logic          ien_i,
  input  logic          idis_i,
  input  logic          iclr_i,
  input  logic [NS-1:0] bits_i,
  output logic [NS-1:0] status_o,
  output logic [NS-1:0] mask_o,
  output logic          irq_o
);
  logic [NS-1:0] status_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      // a new event wins over a clear in the same cycle
      status_q <= (status_q & ~(iclr_i ? bits_i : '0)) | set_i;
      if (ien_i)       mask_q <= mask_q | bits_i;
      else if (idis_i) mask_q <= mask_q & ~bits_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & mask_q);
endmodule

// File: rtl/sru_fwd.sv
module sru_fwd
  import sru_pkg::*;
#(
  parameter int NUM_CH = 63,
  parameter int CW     = 6,
  parameter int DW     = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          unlock_we_i,
  input  logic [CW-1:0] unlock_ch_i,
  input  logic          chn_req_i,
  input  logic          chn_we_i,
  input  logic [CW-1:0] chn_idx_i,
  input  logic [DW-1:0] chn_wdata_i,
  input  logic [DW-1:0] tgt_addr_i,
  output logic [DW-1:0] chn_rdata_o,
  output logic          chn_ack_o,
  output logic          chn_err_o,
  output logic          mst_valid_o,
  output logic          mst_we_o,
  output logic [DW-1:0] mst_addr_o,
  output logic [DW-1:0] mst_wdata_o,
  input  logic          mst_ready_i,
  input  logic          mst_err_i,
  input  logic [DW-1:0] mst_rdata_i,
  output logic          lock_err_o,
  output logic          bus_err_o,
  output logic          armed_o
);
  localparam logic [CW:0] NUM_V = NUM_CH[CW:0];

  fwd_st_e       st_q;
  logic          armed_q;
  logic [CW-1:0] arm_ch_q;
  logic          err_q;
  logic [DW-1:0] rdata_q;
  logic          accept, hit;

  assign accept = (st_q == FS_IDLE) && chn_req_i;
  assign hit    = armed_q && (arm_ch_q == chn_idx_i) && ({1'b0, chn_idx_i} < NUM_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      arm_ch_q <= '0;
    end else if (accept) begin
      armed_q  <= 1'b0;  // every access consumes the arm
    end else if (unlock_we_i) begin
      armed_q  <= {1'b0, unlock_ch_i} < NUM_V;
      arm_ch_q <= unlock_ch_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= FS_IDLE;
      err_q       <= 1'b0;
      rdata_q     <= '0;
      mst_we_o    <= 1'b0;
      mst_addr_o  <= '0;
      mst_wdata_o <= '0;
    end else begin
      unique case (st_q)
        FS_IDLE: if (chn_req_i) begin
          if (hit) begin
            st_q        <= FS_FWD;
            mst_we_o    <= chn_we_i;
            mst_addr_o  <= tgt_addr_i;
            mst_wdata_o <= chn_wdata_i;
          end else begin
            st_q    <= FS_RESP;
            err_q   <= 1'b1;
            rdata_q <= '0;
          end
        end
        FS_FWD: if (mst_ready_i || mst_err_i) begin
          st_q    <= FS_RESP;
          err_q   <= mst_err_i;
          rdata_q <= mst_err_i ? '0 : mst_rdata_i;
        end
        FS_RESP: st_q <= FS_IDLE;
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  assign mst_valid_o = st_q == FS_FWD;
  assign chn_ack_o   = st_q == FS_RESP;
  assign chn_err_o   = chn_ack_o && err_q;
  assign chn_rdata_o = rdata_q;
  assign lock_err_o  = accept && !hit;
  assign bus_err_o   = mst_valid_o && mst_err_i;
  assign armed_o     = armed_q;
endmodule

// File: rtl/sec_remap.sv
module sec_remap
  import sru_pkg::*;
#(
  parameter int          NUM_CH   = 63,
  parameter int          DW       = 32,
  parameter logic [31:0] RANGE_LO = 32'hFFFC_0000,
  localparam int         CW       = $clog2(NUM_CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_req_i,
  input  logic          cfg_we_i,
  input  logic [CW:0]   cfg_addr_i,
  input  logic [DW-1:0] cfg_wdata_i,
  output logic [DW-1:0] cfg_rdata_o,
  input  logic          chn_req_i,
  input  logic          chn_we_i,
  input  logic [CW-1:0] chn_idx_i,
  input  logic [DW-1:0] chn_wdata_i,
  output logic [DW-1:0] chn_rdata_o,
  output logic          chn_ack_o,
  output logic          chn_err_o,
  output logic          mst_valid_o,
  output logic          mst_we_o,
  output logic [DW-1:0] mst_addr_o,
  output logic [DW-1:0] mst_wdata_o,
  input  logic          mst_ready_i,
  input  logic          mst_err_i,
  input  logic [DW-1:0] mst_rdata_i,
  output logic          irq_o
);
  localparam logic [CW:0] NUM_V = NUM_CH[CW:0];

  logic            ctl_sel, cfg_wr, ctl_wr, tbl_wr;
  logic [CW-1:0]   ofs;
  logic [DW-1:0]   tbl_rdata, tgt_addr;
  logic            range_err, lock_err, bus_err, armed_w;
  logic [ST_W-1:0] set_v, status_w, mask_w;

  assign ctl_sel = cfg_addr_i[CW];
  assign ofs     = cfg_addr_i[CW-1:0];
  assign cfg_wr  = cfg_req_i && cfg_we_i;
  assign ctl_wr  = cfg_wr && ctl_sel;
  assign tbl_wr  = cfg_wr && !ctl_sel && ({1'b0, ofs} < NUM_V);

  sru_table #(.NUM_CH(NUM_CH), .CW(CW), .DW(DW), .RANGE_LO(RANGE_LO)) u_table (
    .clk_i, .rst_ni,
    .wr_en_i(tbl_wr), .wr_idx_i(ofs), .wr_data_i(cfg_wdata_i),
    .cfg_idx_i(ofs), .cfg_data_o(tbl_rdata),
    .fwd_idx_i(chn_idx_i), .fwd_addr_o(tgt_addr),
    .range_err_o(range_err)
  );

  always_comb begin
    set_v         = '0;
    set_v[ST_ADR] = range_err;
    set_v[ST_BUS] = bus_err;
    set_v[ST_LCK] = lock_err;
  end

  sru_irq #(.NS(ST_W)) u_irq (
    .clk_i, .rst_ni,
    .set_i (set_v),
    .ien_i (ctl_wr && ofs == CW'(OFS_IEN)),
    .idis_i(ctl_wr && ofs == CW'(OFS_IDIS)),
    .iclr_i(ctl_wr && ofs == CW'(OFS_ICLR)),
    .bits_i(cfg_wdata_i[ST_W-1:0]),
    .status_o(status_w), .mask_o(mask_w), .irq_o
  );

  sru_fwd #(.NUM_CH(NUM_CH), .CW(CW), .DW(DW)) u_fwd (
    .clk_i, .rst_ni,
    .unlock_we_i(ctl_wr && ofs == CW'(OFS_UNLOCK)),
    .unlock_ch_i(cfg_wdata_i[CW-1:0]),
    .chn_req_i, .chn_we_i, .chn_idx_i, .chn_wdata_i,
    .tgt_addr_i(tgt_addr),
    .chn_rdata_o, .chn_ack_o, .chn_err_o,
    .mst_valid_o, .mst_we_o, .mst_addr_o, .mst_wdata_o,
    .mst_ready_i, .mst_err_i, .mst_rdata_i,
    .lock_err_o(lock_err), .bus_err_o(bus_err), .armed_o(armed_w)
  );

  always_comb begin
    cfg_rdata_o = '0;
    if (!ctl_sel) cfg_rdata_o = tbl_rdata;
    else if (ofs == CW'(OFS_STATUS)) cfg_rdata_o[ST_W-1:0] = status_w;
    else if (ofs == CW'(OFS_MASK))   cfg_rdata_o[ST_W-1:0] = mask_w;
  end
endmodule

// File: rtl/sec_remap_chk.sv
module sec_remap_chk
  import sru_pkg::*;
#(
  parameter int          NUM_CH   = 63,
  parameter int          DW       = 32,
  parameter logic [31:0] RANGE_LO = 32'hFFFC_0000,
  parameter int          CW       = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cfg_req_i,
  input logic            cfg_we_i,
  input logic [CW:0]     cfg_addr_i,
  input logic [DW-1:0]   cfg_wdata_i,
  input logic            mst_valid_o,
  input logic            mst_ready_i,
  input logic            mst_err_i,
  input logic [DW-1:0]   mst_addr_o,
  input logic            chn_ack_o,
  input logic            irq_o,
  input logic [ST_W-1:0] status_w,
  input logic            armed_w
);
  localparam logic [CW:0] NUM_V = NUM_CH[CW:0];

  logic bad_tbl_wr, irq_drop_wr;
  assign bad_tbl_wr  = cfg_req_i && cfg_we_i && !cfg_addr_i[CW] &&
                       ({1'b0, cfg_addr_i[CW-1:0]} < NUM_V) &&
                       (cfg_wdata_i < RANGE_LO[DW-1:0]);
  assign irq_drop_wr = cfg_req_i && cfg_we_i && cfg_addr_i[CW] &&
                       (cfg_addr_i[CW-1:0] == CW'(OFS_ICLR) ||
                        cfg_addr_i[CW-1:0] == CW'(OFS_IDIS));

  p_adr_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_tbl_wr |=> status_w[ST_ADR]);

  p_bus_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst_valid_o && mst_err_i) |=> status_w[ST_BUS]);

  p_irq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_drop_wr) |=> irq_o);

  p_fwd_armed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mst_valid_o) |-> $past(armed_w));

  p_addr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst_valid_o && !mst_ready_i && !mst_err_i) |=> (mst_valid_o && $stable(mst_addr_o)));

  p_ack_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(chn_ack_o && mst_valid_o));
endmodule

bind sec_remap sec_remap_chk #(.NUM_CH(NUM_CH), .DW(DW), .RANGE_LO(RANGE_LO), .CW(CW)) u_chk (.*);

// File: tb/sec_remap_tb.sv
`timescale 1ns/1ps
module sec_remap_tb;
  localparam int NUM_CH = 63;
  localparam int DW     = 32;
  localparam int CW     = 6;
  localparam logic [31:0] LO = 32'hFFFC_0000;
  localparam logic [CW:0] A_UNL = 7'd64, A_ST = 7'd65, A_MSK = 7'd66,
                          A_IEN = 7'd67, A_IDIS = 7'd68, A_ICLR = 7'd69;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_req = 0, cfg_we = 0;
  logic [CW:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0, cfg_rdata;
  logic chn_req = 0, chn_we = 0;
  logic [CW-1:0] chn_idx = '0;
  logic [DW-1:0] chn_wdata = '0, chn_rdata;
  logic chn_ack, chn_err, mst_valid, mst_we, irq;
  logic [DW-1:0] mst_addr, mst_wdata;
  logic mst_ready = 0, mst_err = 0;
  logic [DW-1:0] mst_rdata = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  // master responder configuration and observation
  int lat_cfg = 0, wait_cnt = 0, seen_cnt = 0;
  bit err_cfg = 0;
  logic [DW-1:0] rd_cfg = '0, seen_addr = '0, seen_wdata = '0;
  logic seen_we = 0;

  logic [DW-1:0] model [NUM_CH];
  logic [DW-1:0] r_data;
  logic r_err;
  int r_cyc;

  always #2 clk = ~clk;

  sec_remap #(.NUM_CH(NUM_CH), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_req_i(cfg_req), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .chn_req_i(chn_req), .chn_we_i(chn_we), .chn_idx_i(chn_idx),
    .chn_wdata_i(chn_wdata), .chn_rdata_o(chn_rdata),
    .chn_ack_o(chn_ack), .chn_err_o(chn_err),
    .mst_valid_o(mst_valid), .mst_we_o(mst_we), .mst_addr_o(mst_addr),
    .mst_wdata_o(mst_wdata), .mst_ready_i(mst_ready), .mst_err_i(mst_err),
    .mst_rdata_i(mst_rdata), .irq_o(irq)
  );

  always @(negedge clk) begin
    mst_ready <= 1'b0;
    mst_err   <= 1'b0;
    if (mst_valid) begin
      if (wait_cnt >= lat_cfg) begin
        if (err_cfg) mst_err <= 1'b1;
        else         mst_ready <= 1'b1;
        mst_rdata  <= rd_cfg;
        seen_addr  <= mst_addr;
        seen_we    <= mst_we;
        seen_wdata <= mst_wdata;
        seen_cnt   <= seen_cnt + 1;
        wait_cnt   <= 0;
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  function automatic bit in_range(input logic [DW-1:0] v);
    return v >= LO;
  endfunction

  function automatic bit exp_irq(input logic [2:0] st, input logic [2:0] mk);
    return |(st & mk);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [CW:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_req = 1; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_req = 0; cfg_we = 0;
  endtask

  task automatic cfg_rd(input logic [CW:0] a, output logic [DW-1:0] d);
    cfg_req = 1; cfg_we = 0; cfg_addr = a;
    #1 d = cfg_rdata;
    cfg_req = 0;
  endtask

  task automatic chan(input logic [CW-1:0] c, input bit we, input logic [DW-1:0] d);
    @(negedge clk);
    chn_req = 1; chn_we = we; chn_idx = c; chn_wdata = d;
    r_cyc = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      r_cyc++;
      if (chn_ack) break;
    end
    r_data = chn_rdata; r_err = chn_err;
    chn_req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    int sc;
    void'($urandom(32'h5eed));
    for (int i = 0; i < NUM_CH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10 reset state
    cfg_rd(A_ST, v);  chk(v == 0, "R10 status", v, 0);
    cfg_rd(A_MSK, v); chk(v == 0, "R10 mask", v, 0);
    chk(!irq && !mst_valid && !chn_ack, "R10 outputs idle", {irq, mst_valid, chn_ack}, 0);

    // R2 table writes, R3 range boundaries
    cfg_wr(7'd5, 32'hFFFC_0010);  model[5] = 32'hFFFC_0010;
    cfg_rd(7'd5, v);  chk(v == 32'hFFFC_0010, "R2 entry 5 readback", v, 32'hFFFC_0010);
    cfg_wr(7'd62, 32'hFFFF_FFFC); model[62] = 32'hFFFF_FFFC;
    cfg_rd(7'd62, v); chk(v == 32'hFFFF_FFFC, "R2 last entry readback", v, 32'hFFFF_FFFC);
    cfg_wr(7'd0, LO); model[0] = LO;
    cfg_rd(A_ST, v);  chk(v[0] == 0, "R3 lower bound accepted", v, 0);
    cfg_wr(7'd5, 32'hFFFB_FFFC);
    cfg_rd(A_ST, v);  chk(v[0] == 1, "R3 below range flagged", v, 1);
    cfg_rd(7'd5, v);  chk(v == model[5], "R4 entry kept", v, model[5]);
    cfg_wr(A_ICLR, 32'h1);
    cfg_rd(A_ST, v);  chk(v == 0, "R7 clear address error", v, 0);

    // R8 access without unlock
    sc = seen_cnt;
    chan(6'd5, 1, 32'h1111_2222);
    chk(r_err == 1 && seen_cnt == sc, "R8 locked access blocked", {31'd0, r_err}, 1);
    cfg_rd(A_ST, v);  chk(v[2] == 1, "R8 unlock error bit", v, 4);
    cfg_wr(A_ICLR, 32'h7);

    // R1 R9 armed write with latency
    cfg_wr(A_UNL, 32'd5);
    lat_cfg = 3; err_cfg = 0;
    chan(6'd5, 1, 32'h1234_5678);
    chk(r_err == 0 && seen_addr == model[5], "R1 write target addr", seen_addr, model[5]);
    chk(seen_we == 1 && seen_wdata == 32'h1234_5678, "R1 write data passed", seen_wdata, 32'h1234_5678);
    chk(r_cyc == lat_cfg + 2, "R9 stall cycles", r_cyc, lat_cfg + 2);

    // R8 one-shot: repeat without unlock
    sc = seen_cnt;
    chan(6'd5, 0, 0);
    chk(r_err == 1 && seen_cnt == sc, "R8 arm consumed", {31'd0, r_err}, 1);

    // R1 armed read
    cfg_wr(A_UNL, 32'd5);
    lat_cfg = 0; rd_cfg = 32'hCAFE_F00D;
    chan(6'd5, 0, 0);
    chk(r_err == 0 && r_data == 32'hCAFE_F00D && seen_we == 0, "R1 read data", r_data, 32'hCAFE_F00D);

    // R8 wrong channel armed
    cfg_wr(A_UNL, 32'd7);
    sc = seen_cnt;
    chan(6'd5, 0, 0);
    chk(r_err == 1 && seen_cnt == sc, "R8 other channel armed", {31'd0, r_err}, 1);
    cfg_wr(A_ICLR, 32'h7);

    // R5 bus error, R6 R7 interrupt scheme
    cfg_wr(A_IEN, 32'h2);
    cfg_rd(A_MSK, v); chk(v == 2, "R6 enable sets mask", v, 2);
    chk(irq == 0, "R7 irq idle without status", irq, 0);
    cfg_wr(A_UNL, 32'd62);
    err_cfg = 1; lat_cfg = 1;
    chan(6'd62, 1, 32'hDEAD_BEEF);
    err_cfg = 0;
    chk(r_err == 1, "R5 chn error on bus error", r_err, 1);
    cfg_rd(A_ST, v);  chk(v == 2, "R5 bus error bit", v, 2);
    chk(irq == exp_irq(3'd2, 3'd2), "R7 irq raised", irq, 1);
    cfg_wr(A_IDIS, 32'h2);
    cfg_rd(A_MSK, v); chk(v == 0, "R6 disable clears mask", v, 0);
    chk(irq == 0, "R7 irq masked", irq, 0);
    cfg_rd(A_ST, v);  chk(v == 2, "R7 status kept while masked", v, 2);
    cfg_wr(A_IEN, 32'h2);
    chk(irq == 1, "R7 irq re-enabled", irq, 1);
    cfg_wr(A_ICLR, 32'h2);
    chk(irq == 0, "R7 irq cleared", irq, 0);
    cfg_wr(A_IDIS, 32'h7);

    // random forwarding
    for (int it = 0; it < 40; it++) begin
      logic [CW-1:0] c;
      logic [DW-1:0] d;
      bit we;
      c = CW'($urandom % NUM_CH);
      if ($urandom % 4 == 0) begin
        d = $urandom % LO;
        cfg_wr({1'b0, c}, d);
        cfg_rd({1'b0, c}, v); chk(v == model[c], "R4 random reject keeps", v, model[c]);
        cfg_rd(A_ST, v);      chk(v[0] == 1, "R3 random reject flagged", v, 1);
        cfg_wr(A_ICLR, 32'h1);
      end else begin
        d = LO | ($urandom & 32'h0003_FFFC);
        cfg_wr({1'b0, c}, d);
        model[c] = d;
      end
      cfg_wr(A_UNL, {26'd0, c});
      lat_cfg = $urandom % 4;
      rd_cfg  = $urandom;
      we      = 1'($urandom);
      d       = $urandom;
      chan(c, we, d);
      chk(r_err == 0 && seen_addr == model[c], "R1 random target", seen_addr, model[c]);
      if (we) chk(seen_wdata == d, "R1 random wdata", seen_wdata, d);
      else    chk(r_data == rd_cfg, "R1 random rdata", r_data, rd_cfg);
      chk(r_cyc == lat_cfg + 2, "R9 random stall", r_cyc, lat_cfg + 2);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule